// File: doc/BRIEF.md
# External Interrupt Request Controller

This block gathers the external interrupt sources of a small microcontroller core into a single request to the CPU. It takes one nonmaskable line and eight maskable request lines. Eight key-sense inputs are merged into one of the maskable lines. All pins pass through a two-flop synchronizer. Each maskable line is either level sensed or falling-edge sensed, and edges are held in pending flags. The block picks a winner by fixed priority and presents its vector number in a register. That register holds still until the CPU acknowledges it.

Software configures the block through a small write port with four addresses: line sense modes, line enables, key masks and the nonmaskable edge polarity. The CPU supplies its global mask bit, which blocks the eight maskable lines but never the nonmaskable one. The CPU also drives an acknowledge strobe. On acknowledge the block asserts a one-cycle request to set the global mask, and it clears the pending flag of the source it served.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, intReq is 0 and vecNum is 0. All line enables are 0, all lines are level sensed, all key mask bits are 1 and the nonmaskable edge select is 0 (falling).
- R2: A write with wrEn high stores wrData at wrAddr. Address 0 holds the sense bits (bit i set means line i is falling-edge sensed, clear means low-level sensed). Address 1 holds the line enables (bit i enables line i). Address 2 holds the key masks (bit k set disables key k). Bit 0 of address 3 selects the nonmaskable edge (1 rising, 0 falling).
- R3: A level-sensed line driven low just before rising edge 1 raises intReq at rising edge 3. A falling edge on an edge-sensed line that is sampled at edge 1 raises intReq at edge 4.
- R4: A level-sensed, enabled line requests for as long as its pin stays low, and it latches nothing. After its pin returns high it produces no further request.
- R5: An enabled, edge-sensed line latches each falling edge as pending. Acknowledging its vector clears the flag, and an edge detected in the acknowledge cycle is kept.
- R6: The nonmaskable input raises vector 3 on its selected edge, whatever the global mask bit is. The opposite edge has no effect.
- R7: A maskable line produces no request while its enable bit is 0, or while globalMask is 1.
- R8: Line i uses vector 4+i. When several sources are pending, the nonmaskable input wins first, then line 0, and line 7 comes last.
- R9: Line 6 is also active while any key pin whose mask bit is 0 is low. Key pins whose mask bit is 1 have no effect.
- R10: Once intReq is high, intReq and vecNum hold steady until ackIn. intReq falls at the edge that samples ackIn high.
- R11: setMask is high exactly in the cycles where intReq and ackIn are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| nmiPin | input | 1 | Nonmaskable interrupt pin |
| irqPin | input | 8 | Maskable request pins, active low |
| keyPin | input | 8 | Key-sense pins, active low, merged into line 6 |
| wrEn | input | 1 | Configuration write strobe |
| wrAddr | input | 2 | Configuration register address |
| wrData | input | 8 | Configuration write data |
| globalMask | input | 1 | CPU global mask bit |
| ackIn | input | 1 | CPU acknowledge of the presented vector |
| intReq | output | 1 | Interrupt request to the CPU |
| vecNum | output | 6 | Vector number of the presented request |
| setMask | output | 1 | Request to set the global mask bit |

## Verification
The assertions check the handshake on every cycle: the vector holds steady while a request waits, the request drops after acknowledge, setMask pulses together with acknowledge, the vector stays in the legal range, and a request raised under the global mask is always the nonmaskable one. Synchronizer latency, edge polarity, level versus edge sensing, key masking and priority order depend on pin history and configuration. Only the bench's scenarios can show these. Its reference model compares intReq, vecNum and setMask on every clock.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int IRQ_N        = 8;
  localparam int KEY_N        = 8;
  localparam int KEY_LINE     = 6;
  localparam int VEC_W        = 6;
  localparam int NMI_VEC      = 3;
  localparam int IRQ_VEC_BASE = 4;
  localparam int ADDR_W       = 2;
  localparam int DATA_W       = 8;
  localparam int PIN_W        = 1 + IRQ_N + KEY_N;

  typedef enum logic [ADDR_W-1:0] {
    REG_SENSE   = 2'd0,
    REG_ENABLE  = 2'd1,
    REG_KEYMASK = 2'd2,
    REG_NMICFG  = 2'd3
  } regAddr_t;

  // control -> datapath
  typedef struct packed {
    logic             clrNmi;
    logic [IRQ_N-1:0] clrIrq;
  } ackStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic             nmiPend;
    logic [IRQ_N-1:0] irqReq;
  } reqBus_t;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int   W       = 1,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= {W{RST_VAL}};
      stage2 <= {W{RST_VAL}};
    end else begin
      stage1 <= din;
      stage2 <= stage1;
    end
  end

  assign dout = stage2;
endmodule

// File: rtl/ext_irq_datapath.sv
module ext_irq_datapath
  import ext_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiPin,
  input  logic [IRQ_N-1:0]  irqPin,
  input  logic [KEY_N-1:0]  keyPin,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  ackStrobe_t        strobe,
  output reqBus_t           reqs
);
  logic [IRQ_N-1:0] senseEdge;
  logic [IRQ_N-1:0] lineEn;
  logic [KEY_N-1:0] keyMask;
  logic             nmiRise;

  logic [PIN_W-1:0] pinSync;
  logic             nmiSync;
  logic [IRQ_N-1:0] irqSync;
  logic [KEY_N-1:0] keySync;
  logic             keyHit;
  logic [IRQ_N-1:0] lineAct;
  logic [IRQ_N-1:0] prevAct;
  logic [IRQ_N-1:0] fallEdge;
  logic [IRQ_N-1:0] irqPend;
  logic             nmiPrev;
  logic             nmiEdge;
  logic             nmiPend;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      senseEdge <= '0;
      lineEn    <= '0;
      keyMask   <= '1;
      nmiRise   <= 1'b0;
    end else if (wrEn) begin
      unique case (regAddr_t'(wrAddr))
        REG_SENSE:   senseEdge <= wrData[IRQ_N-1:0];
        REG_ENABLE:  lineEn    <= wrData[IRQ_N-1:0];
        REG_KEYMASK: keyMask   <= wrData[KEY_N-1:0];
        REG_NMICFG:  nmiRise   <= wrData[0];
        default:     ;
      endcase
    end
  end

  ext_irq_sync #(.W(PIN_W), .RST_VAL(1'b1)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({nmiPin, irqPin, keyPin}),
    .dout (pinSync)
  );

  assign {nmiSync, irqSync, keySync} = pinSync;
  assign keyHit = |(~keySync & ~keyMask);

  genvar gi;
  generate
    for (gi = 0; gi < IRQ_N; gi++) begin : gLine
      if (gi == KEY_LINE) begin : gKey
        assign lineAct[gi] = ~irqSync[gi] | keyHit;
      end else begin : gPlain
        assign lineAct[gi] = ~irqSync[gi];
      end
    end
  endgenerate

  assign fallEdge = lineAct & ~prevAct;
  assign nmiEdge  = nmiRise ? (nmiSync & ~nmiPrev) : (~nmiSync & nmiPrev);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevAct <= '0;
      nmiPrev <= 1'b1;
      irqPend <= '0;
      nmiPend <= 1'b0;
    end else begin
      prevAct <= lineAct;
      nmiPrev <= nmiSync;
      irqPend <= (irqPend & ~strobe.clrIrq) | (fallEdge & lineEn & senseEdge);
      nmiPend <= (nmiPend & ~strobe.clrNmi) | nmiEdge;
    end
  end

  always_comb begin
    reqs.nmiPend = nmiPend;
    for (int i = 0; i < IRQ_N; i++) begin
      reqs.irqReq[i] = lineEn[i] & (senseEdge[i] ? irqPend[i] : lineAct[i]);
    end
  end
endmodule

// File: rtl/ext_irq_control.sv
module ext_irq_control
  import ext_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  reqBus_t          reqs,
  input  logic             globalMask,
  input  logic             ackIn,
  output logic             intReq,
  output logic [VEC_W-1:0] vecNum,
  output logic             setMask,
  output ackStrobe_t       strobe
);
  logic             winValid;
  logic [VEC_W-1:0] winVec;
  logic             accept;

  // fixed priority: nonmaskable first, then the lowest line index
  always_comb begin
    winValid = 1'b0;
    winVec   = '0;
    if (reqs.nmiPend) begin
      winValid = 1'b1;
      winVec   = VEC_W'(NMI_VEC);
    end else if (!globalMask) begin
      for (int i = IRQ_N - 1; i >= 0; i--) begin
        if (reqs.irqReq[i]) begin
          winValid = 1'b1;
          winVec   = VEC_W'(IRQ_VEC_BASE + i);
        end
      end
    end
  end

  assign accept  = intReq & ackIn;
  assign setMask = accept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intReq <= 1'b0;
      vecNum <= '0;
    end else if (intReq) begin
      if (ackIn) intReq <= 1'b0;
    end else if (winValid) begin
      intReq <= 1'b1;
      vecNum <= winVec;
    end
  end

  always_comb begin
    strobe.clrNmi = accept && (vecNum == VEC_W'(NMI_VEC));
    for (int i = 0; i < IRQ_N; i++) begin
      strobe.clrIrq[i] = accept && (vecNum == VEC_W'(IRQ_VEC_BASE + i));
    end
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiPin,
  input  logic [IRQ_N-1:0]  irqPin,
  input  logic [KEY_N-1:0]  keyPin,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              globalMask,
  input  logic              ackIn,
  output logic              intReq,
  output logic [VEC_W-1:0]  vecNum,
  output logic              setMask
);
  ackStrobe_t strobe;
  reqBus_t    reqs;

  ext_irq_datapath uData (
    .clk    (clk),
    .rstN   (rstN),
    .nmiPin (nmiPin),
    .irqPin (irqPin),
    .keyPin (keyPin),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .strobe (strobe),
    .reqs   (reqs)
  );

  ext_irq_control uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqs       (reqs),
    .globalMask (globalMask),
    .ackIn      (ackIn),
    .intReq     (intReq),
    .vecNum     (vecNum),
    .setMask    (setMask),
    .strobe     (strobe)
  );
endmodule

// File: rtl/ext_irq_ctrl_checker.sv
module ext_irq_ctrl_checker
  import ext_irq_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             globalMask,
  input logic             ackIn,
  input logic             intReq,
  input logic [VEC_W-1:0] vecNum,
  input logic             setMask
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      assert_reset_idle_R1: assert (!intReq && vecNum == '0)
        else $error("request active during reset");
    end
  end

  assert_vec_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && !ackIn) |=> (intReq && $stable(vecNum)))
    else $error("vector moved before acknowledge");

  assert_drop_on_ack_R10: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && ackIn) |=> !intReq)
    else $error("request held after acknowledge");

  assert_setmask_only_R11: assert property (@(posedge clk) disable iff (!rstN)
    setMask |-> (intReq && ackIn))
    else $error("setMask without acceptance");

  assert_setmask_always_R11: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && ackIn) |-> setMask)
    else $error("acceptance without setMask");

  assert_vec_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> (vecNum >= VEC_W'(NMI_VEC) && vecNum <= VEC_W'(IRQ_VEC_BASE + IRQ_N - 1)))
    else $error("vector out of range");

  assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(intReq) && $past(globalMask)) |-> (vecNum == VEC_W'(NMI_VEC)))
    else $error("maskable request raised under global mask");
endmodule

bind ext_irq_ctrl ext_irq_ctrl_checker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .globalMask (globalMask),
  .ackIn      (ackIn),
  .intReq     (intReq),
  .vecNum     (vecNum),
  .setMask    (setMask)
);

// File: tb/ext_irq_ctrl_test.sv
module ext_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       nmiPin = 1'b1;
  logic [7:0] irqPin = 8'hFF;
  logic [7:0] keyPin = 8'hFF;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic       globalMask = 1'b0;
  logic       ackIn = 1'b0;
  logic       intReq;
  logic [5:0] vecNum;
  logic       setMask;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string curReq = "R1";

  always #5 clk = ~clk;

  ext_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .nmiPin(nmiPin), .irqPin(irqPin), .keyPin(keyPin),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .globalMask(globalMask),
    .ackIn(ackIn), .intReq(intReq), .vecNum(vecNum), .setMask(setMask)
  );

  task automatic check(bit ok, string rq, string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", rq, msg);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct packed {
    logic       nmi;
    logic [7:0] irq;
    logic [7:0] key;
  } pinSample_t;

  localparam pinSample_t IDLE = '{nmi: 1'b1, irq: 8'hFF, key: 8'hFF};

  pinSample_t hist[$];
  logic [7:0] mSense, mEn, mKeyMask, mPend, mPrevAct;
  logic       mNmiRise, mNmiPend, mPrevNmi, mIntReq;
  logic [5:0] mVec;

  always @(posedge clk or negedge rstN) begin : modelStep
    pinSample_t seen;
    logic [7:0] act, req, edges, clr;
    logic       nmiEv, clrN, wValid;
    logic [5:0] wVec;
    if (!rstN) begin
      mSense = 8'h00; mEn = 8'h00; mKeyMask = 8'hFF; mPend = 8'h00; mPrevAct = 8'h00;
      mNmiRise = 1'b0; mNmiPend = 1'b0; mPrevNmi = 1'b1; mIntReq = 1'b0; mVec = 6'd0;
      hist = '{IDLE, IDLE};
    end else begin
      seen = hist[1];  // sample taken two edges ago
      for (int i = 0; i < 8; i++) act[i] = ~seen.irq[i];
      if (|(~seen.key & ~mKeyMask)) act[6] = 1'b1;
      edges = act & ~mPrevAct;
      nmiEv = mNmiRise ? (seen.nmi && !mPrevNmi) : (!seen.nmi && mPrevNmi);
      for (int i = 0; i < 8; i++) req[i] = mEn[i] && (mSense[i] ? mPend[i] : act[i]);
      wValid = 1'b0; wVec = 6'd0;
      if (mNmiPend) begin wValid = 1'b1; wVec = 6'd3; end
      else if (!globalMask) begin
        for (int i = 0; i < 8; i++) begin
          if (!wValid && req[i]) begin wValid = 1'b1; wVec = 6'(4 + i); end
        end
      end
      clr = 8'h00; clrN = 1'b0;
      if (mIntReq && ackIn) begin
        if (mVec == 6'd3) clrN = 1'b1;
        else clr[mVec - 6'd4] = 1'b1;
      end
      mPend    = (mPend & ~clr) | (edges & mEn & mSense);
      mNmiPend = (mNmiPend && !clrN) || nmiEv;
      if (mIntReq) begin
        if (ackIn) mIntReq = 1'b0;
      end else if (wValid) begin
        mIntReq = 1'b1;
        mVec = wVec;
      end
      if (wrEn) begin
        case (wrAddr)
          2'd0: mSense   = wrData;
          2'd1: mEn      = wrData;
          2'd2: mKeyMask = wrData;
          default: mNmiRise = wrData[0];
        endcase
      end
      mPrevAct = act;
      mPrevNmi = seen.nmi;
      hist.push_front('{nmi: nmiPin, irq: irqPin, key: keyPin});
      void'(hist.pop_back());
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rstN && !done) begin
      check(intReq === mIntReq && vecNum === mVec && setMask === (mIntReq && ackIn), curReq,
            $sformatf("model mismatch got req=%0b vec=%0d set=%0b expected req=%0b vec=%0d set=%0b",
                      intReq, vecNum, setMask, mIntReq, mVec, mIntReq && ackIn));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic expectReq(logic [5:0] vec, string rq);
    int waited = 0;
    curReq = rq;
    #1;
    while (!intReq && waited < 20) begin
      @(negedge clk); #1;
      waited++;
    end
    check(intReq === 1'b1 && vecNum === vec, rq,
          $sformatf("got req=%0b vec=%0d expected req=1 vec=%0d", intReq, vecNum, vec));
  endtask

  task automatic ackNow();
    @(negedge clk);
    ackIn = 1'b1;
    @(negedge clk);
    ackIn = 1'b0;
  endtask

  task automatic expectQuiet(int n, string rq);
    curReq = rq;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      check(intReq === 1'b0, rq, $sformatf("got req=%0b vec=%0d expected req=0", intReq, vecNum));
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    tick(3);
    #1;
    check(intReq === 1'b0 && vecNum === 6'd0 && setMask === 1'b0, "R1",
          $sformatf("reset got req=%0b vec=%0d expected req=0 vec=0", intReq, vecNum));
    @(negedge clk);
    rstN = 1'b1;

    // R9 and R1: key masks start at all ones, so keys do nothing
    writeReg(2'd1, 8'h40);
    keyPin[2] = 1'b0;
    expectQuiet(8, "R9");
    keyPin[2] = 1'b1;
    tick(4);

    // R3/R4: level-sensed line 2
    writeReg(2'd1, 8'h04);
    curReq = "R3";
    irqPin[2] = 1'b0;
    tick(2); #1;
    check(intReq === 1'b0, "R3", $sformatf("early got req=%0b expected 0", intReq));
    tick(1); #1;
    check(intReq === 1'b1 && vecNum === 6'd6, "R3",
          $sformatf("third edge got req=%0b vec=%0d expected 1/6", intReq, vecNum));
    curReq = "R10";
    tick(5); #1;
    check(intReq === 1'b1 && vecNum === 6'd6, "R10",
          $sformatf("held got req=%0b vec=%0d expected 1/6", intReq, vecNum));
    @(negedge clk);
    ackIn = 1'b1; #1;
    check(setMask === 1'b1, "R11", $sformatf("got setMask=%0b expected 1", setMask));
    @(negedge clk);
    ackIn = 1'b0; #1;
    check(intReq === 1'b0, "R10", $sformatf("after ack got req=%0b expected 0", intReq));
    tick(1); #1;
    check(intReq === 1'b1 && vecNum === 6'd6, "R4",
          $sformatf("low pin again got req=%0b vec=%0d expected 1/6", intReq, vecNum));
    @(negedge clk);
    ackIn = 1'b1; globalMask = 1'b1;
    @(negedge clk);
    ackIn = 1'b0;
    expectQuiet(6, "R7");
    irqPin[2] = 1'b1;
    tick(4);
    globalMask = 1'b0;
    expectQuiet(6, "R4");

    // R5: edge-sensed line 5
    writeReg(2'd0, 8'h20);
    writeReg(2'd1, 8'h20);
    @(negedge clk); irqPin[5] = 1'b0;
    @(negedge clk); irqPin[5] = 1'b1;
    expectReq(6'd9, "R5");
    ackNow();
    expectQuiet(6, "R5");

    // R7: disabled line requests nothing
    irqPin[3] = 1'b0;
    expectQuiet(6, "R7");
    irqPin[3] = 1'b1;
    tick(4);

    // R8: two edges latched under the global mask, served by priority
    writeReg(2'd0, 8'h12);
    writeReg(2'd1, 8'h12);
    globalMask = 1'b1;
    @(negedge clk); irqPin[1] = 1'b0; irqPin[4] = 1'b0;
    @(negedge clk); irqPin[1] = 1'b1; irqPin[4] = 1'b1;
    expectQuiet(6, "R7");
    globalMask = 1'b0;
    expectReq(6'd5, "R8");
    ackNow();
    expectReq(6'd8, "R8");
    ackNow();
    expectQuiet(4, "R8");

    // R6: nonmaskable on falling edge, regardless of global mask
    globalMask = 1'b1;
    nmiPin = 1'b0;
    expectReq(6'd3, "R6");
    ackNow();
    nmiPin = 1'b1;
    expectQuiet(6, "R6");

    // R2/R6: select rising edge
    writeReg(2'd3, 8'h01);
    nmiPin = 1'b0;
    expectQuiet(6, "R2");
    nmiPin = 1'b1;
    expectReq(6'd3, "R6");
    ackNow();
    globalMask = 1'b0;
    tick(3);

    // R8: nonmaskable against line 0 in the same cycle
    writeReg(2'd3, 8'h00);
    writeReg(2'd0, 8'h01);
    writeReg(2'd1, 8'h01);
    @(negedge clk); nmiPin = 1'b0; irqPin[0] = 1'b0;
    expectReq(6'd3, "R8");
    ackNow();
    expectReq(6'd4, "R8");
    irqPin[0] = 1'b1; nmiPin = 1'b1;
    ackNow();
    expectQuiet(4, "R8");

    // R9: key 3 unmasked drives line 6, key 5 stays masked
    writeReg(2'd0, 8'h40);
    writeReg(2'd1, 8'h40);
    writeReg(2'd2, 8'hF7);
    keyPin[5] = 1'b0;
    expectQuiet(6, "R9");
    keyPin[5] = 1'b1;
    tick(3);
    keyPin[3] = 1'b0;
    expectReq(6'd10, "R9");
    ackNow();
    keyPin[3] = 1'b1;
    expectQuiet(6, "R9");

    tick(2);
    finishRun();
  end
endmodule